// File: doc/BRIEF.md
# Fuse Array Strobe Read Port

This block is a small register-mapped read port in front of a one-time-programmable fuse array. Software drives the array's control pins directly by writing one control register. That register holds an active-low chip-select, a strobe, a load enable, an active-low program-enable and a fuse address. A second register returns the fuse contents at the captured address, but only while the array is selected, loaded and strobed. Outside that window the second register reads as zero.

A parameter chooses one of two variants. The byte variant returns 8 bits per address. The word variant returns 32 bits per address. It also adds a power-down bit, a read-sense bit and a strobe-shift-select bit, and its address field sits higher in the control register. A typical read works in four steps. Software first writes a read-setup value: load and program-enable set, chip-select clear. It then writes the address with strobe raised, reads the data register, and finally clears strobe. After the last read it writes the standby value. The fuse contents are behavioural. Each location holds a value computed from a seed parameter.

Top module: `efuse_read_port`

## Requirements
- R1: After reset the control register reads 0x00000009 in the byte variant (program-enable and chip-select set) and 0x00000021 in the word variant (power-down and chip-select set).
- R2: A write to offset 0x0 stores the written value masked to the implemented bits, and a read of offset 0x0 returns it. The byte variant keeps mask 0x0000FFCF: chip-select bit 0, strobe bit 1, load bit 2, program-enable bit 3 and address bits 15:6. The word variant keeps mask 0x03FF02AF: bits 0-3 as in the byte variant, power-down bit 5, read-sense bit 7, strobe-shift-select bit 9 and address bits 25:16.
- R3: A read of offset 0x4 returns the captured fuse data only while chip-select (bit 0) is 0, load (bit 2) is 1 and strobe (bit 1) is 1. Otherwise it returns zero.
- R4: The fuse location at address a holds (a * 0x9E3779B1) XOR FUSE_SEED, computed in 32 bits. The word variant returns all 32 bits. The byte variant returns the low 8 bits, zero-extended.
- R5: The address field is captured only on a control write that takes strobe from 0 to 1. Changing the address while strobe stays high leaves the returned data unchanged.
- R6: In the word variant, a read of offset 0x4 returns zero while power-down (bit 5) is set, whatever the other bits hold.
- R7: Every read request gets bus_rvalid_o high on exactly the following cycle, with its data on bus_rdata_o. bus_rdata_o is zero in every cycle where bus_rvalid_o is low.
- R8: Writes to offset 0x4 or to any offset other than 0x0 change nothing. Reads of offsets other than 0x0 and 0x4 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access request for this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the request |
| bus_rdata_o | output | 32 | Read data |

## Verification
The assertions assume that the bus inputs are stable and known at each rising edge while reset is released. They also assume that a request lasts one cycle and needs no handshake. The bench drives every input on the falling edge and holds bus_valid_i for exactly one cycle per access. Both variants run side by side on the same stimulus. The stimulus includes address fields that overlap the word variant's extra control bits, so each variant's masking is exercised.

// File: rtl/efuse_rd_pkg.sv
package efuse_rd_pkg;
  localparam int unsigned BUS_AW = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned FA_W   = 10;

  localparam int unsigned B_CS    = 0;
  localparam int unsigned B_STB   = 1;
  localparam int unsigned B_LOAD  = 2;
  localparam int unsigned B_PGEN  = 3;
  localparam int unsigned B_PD    = 5;
  localparam int unsigned B_SENSE = 7;
  localparam int unsigned B_SSEL  = 9;

  localparam logic [BUS_AW-1:0] OFS_CTRL = 4'h0;
  localparam logic [BUS_AW-1:0] OFS_DOUT = 4'h4;

  function automatic int unsigned addr_lsb(bit wide);
    return wide ? 16 : 6;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_mask(bit wide);
    logic [DATA_W-1:0] m;
    m = '0;
    m[B_CS] = 1'b1;
    m[B_STB] = 1'b1;
    m[B_LOAD] = 1'b1;
    m[B_PGEN] = 1'b1;
    if (wide) begin
      m[B_PD] = 1'b1;
      m[B_SENSE] = 1'b1;
      m[B_SSEL] = 1'b1;
    end
    m[addr_lsb(wide) +: FA_W] = '1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] standby_val(bit wide);
    logic [DATA_W-1:0] v;
    v = '0;
    v[B_CS] = 1'b1;
    if (wide) v[B_PD] = 1'b1;
    else      v[B_PGEN] = 1'b1;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] fuse_word(logic [FA_W-1:0] a, logic [DATA_W-1:0] seed);
    logic [DATA_W-1:0] p;
    p = {{(DATA_W-FA_W){1'b0}}, a} * 32'h9E3779B1;
    return p ^ seed;
  endfunction
endpackage

// File: rtl/efuse_ctrl_regs.sv
module efuse_ctrl_regs
  import efuse_rd_pkg::*;
#(
  parameter bit WIDE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dout_i,
  output logic              cs_o,
  output logic              stb_o,
  output logic              load_o,
  output logic              pd_o,
  output logic              stb_rise_o,
  output logic [FA_W-1:0]   fa_addr_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] MASK = ctrl_mask(WIDE);
  localparam logic [DATA_W-1:0] RST  = standby_val(WIDE);
  localparam int unsigned       ALSB = addr_lsb(WIDE);

  logic [DATA_W-1:0] ctrl_q, ctrl_d, rd_mux, rdata_q;
  logic              wr_ctrl, rd_req, rvalid_q;

  assign wr_ctrl = valid_i && write_i && (addr_i == OFS_CTRL);
  assign rd_req  = valid_i && !write_i;
  assign ctrl_d  = wr_ctrl ? (wdata_i & MASK) : ctrl_q;

  // capture point for the array: new strobe high, old strobe low
  assign stb_rise_o = ctrl_d[B_STB] && !ctrl_q[B_STB];
  assign fa_addr_o  = ctrl_d[ALSB +: FA_W];

  assign cs_o   = ctrl_q[B_CS];
  assign stb_o  = ctrl_q[B_STB];
  assign load_o = ctrl_q[B_LOAD];
  assign pd_o   = ctrl_q[B_PD];

  always_comb begin
    unique case (addr_i)
      OFS_CTRL: rd_mux = ctrl_q;
      OFS_DOUT: rd_mux = dout_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= RST;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      rvalid_q <= rd_req;
      rdata_q  <= rd_req ? rd_mux : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  p_ctrl_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & ~MASK) == '0);
  p_ctrl_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && write_i && addr_i == OFS_CTRL) |=> $stable(ctrl_q));
  p_rvalid_next_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !write_i) |=> rvalid_o);
  p_rvalid_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && !write_i) |=> !rvalid_o);
  p_rdata_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == '0);
endmodule

// File: rtl/efuse_fuse_array.sv
module efuse_fuse_array
  import efuse_rd_pkg::*;
#(
  parameter bit                WIDE      = 1'b1,
  parameter logic [DATA_W-1:0] FUSE_SEED = 32'h5A3C_0F81
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_rise_i,
  input  logic [FA_W-1:0]   addr_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned DW = WIDE ? DATA_W : 8;

  logic [FA_W-1:0]   addr_q;
  logic [DATA_W-1:0] cell_w;
  logic [DW-1:0]     data_q;

  assign cell_w = fuse_word(addr_i, FUSE_SEED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (stb_rise_i) begin
      addr_q <= addr_i;
      data_q <= cell_w[DW-1:0];
    end
  end

  generate
    if (DW == DATA_W) begin : g_word
      assign data_o = data_q;
    end else begin : g_byte
      assign data_o = {{(DATA_W-DW){1'b0}}, data_q};
    end
  endgenerate

  p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_rise_i |=> $stable(addr_q));
  p_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_rise_i |=> $stable(data_o));
endmodule

// File: rtl/efuse_dout_gate.sv
module efuse_dout_gate
  import efuse_rd_pkg::*;
#(
  parameter bit WIDE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              stb_i,
  input  logic              load_i,
  input  logic              pd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] dout_o
);
  logic open_w;

  generate
    if (WIDE) begin : g_pd
      assign open_w = !cs_i && load_i && stb_i && !pd_i;
      p_pd_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pd_i |-> dout_o == '0);
    end else begin : g_nopd
      logic unused_pd;
      assign unused_pd = pd_i;
      assign open_w = !cs_i && load_i && stb_i;
    end
  endgenerate

  assign dout_o = open_w ? data_i : '0;

  p_dout_closed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i || !load_i || !stb_i) |-> dout_o == '0);
endmodule

// File: rtl/efuse_read_port.sv
module efuse_read_port
  import efuse_rd_pkg::*;
#(
  parameter bit                WIDE_MODE = 1'b1,
  parameter logic [DATA_W-1:0] FUSE_SEED = 32'h5A3C_0F81
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_rvalid_o,
  output logic [DATA_W-1:0] bus_rdata_o
);
  logic              cs_w, stb_w, load_w, pd_w, stb_rise_w;
  logic [FA_W-1:0]   fa_addr_w;
  logic [DATA_W-1:0] cell_data_w, dout_w;

  efuse_ctrl_regs #(.WIDE(WIDE_MODE)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (bus_valid_i),
    .write_i    (bus_write_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .dout_i     (dout_w),
    .cs_o       (cs_w),
    .stb_o      (stb_w),
    .load_o     (load_w),
    .pd_o       (pd_w),
    .stb_rise_o (stb_rise_w),
    .fa_addr_o  (fa_addr_w),
    .rvalid_o   (bus_rvalid_o),
    .rdata_o    (bus_rdata_o)
  );

  efuse_fuse_array #(.WIDE(WIDE_MODE), .FUSE_SEED(FUSE_SEED)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_rise_i (stb_rise_w),
    .addr_i     (fa_addr_w),
    .data_o     (cell_data_w)
  );

  efuse_dout_gate #(.WIDE(WIDE_MODE)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_i   (cs_w),
    .stb_i  (stb_w),
    .load_i (load_w),
    .pd_i   (pd_w),
    .data_i (cell_data_w),
    .dout_o (dout_w)
  );

  p_standby_after_reset_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (cs_w && !stb_w && !load_w));
endmodule

// File: tb/efuse_read_port_tb.sv
`timescale 1ns/1ps
module efuse_read_port_tb;
  localparam logic [31:0] SEED = 32'h5A3C_0F81;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic        rv_w, rv_b;
  logic [31:0] rd_w, rd_b;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  logic [31:0] m_ctrl [2];
  logic [31:0] m_data [2];
  logic        m_rv   [2];
  logic [31:0] m_rd   [2];

  always #2.5 clk = ~clk;

  efuse_read_port #(.WIDE_MODE(1'b1), .FUSE_SEED(SEED)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rvalid_o(rv_w), .bus_rdata_o(rd_w));

  efuse_read_port #(.WIDE_MODE(1'b0), .FUSE_SEED(SEED)) u_dut_byte (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rvalid_o(rv_b), .bus_rdata_o(rd_b));

  function automatic logic [31:0] mask_of(int v);
    return (v == 1) ? 32'h03FF_02AF : 32'h0000_FFCF;
  endfunction

  function automatic logic [31:0] fuse_of(int v, logic [9:0] a);
    logic [31:0] f;
    f = (32'(a) * 32'h9E3779B1) ^ SEED;
    return (v == 1) ? f : (f & 32'hFF);
  endfunction

  function automatic bit open_of(int v, logic [31:0] c);
    return !c[0] && c[2] && c[1] && !(v == 1 && c[5]);
  endfunction

  // reference model, index 0 = byte variant, 1 = word variant
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl[0] = 32'h9; m_ctrl[1] = 32'h21;
      for (int v = 0; v < 2; v++) begin
        m_data[v] = '0; m_rv[v] = 1'b0; m_rd[v] = '0;
      end
    end else begin
      for (int v = 0; v < 2; v++) begin
        logic [31:0] nc;
        logic [31:0] dout;
        logic [9:0]  a;
        dout = open_of(v, m_ctrl[v]) ? m_data[v] : 32'h0;
        m_rv[v] = bus_valid && !bus_write;
        m_rd[v] = 32'h0;
        if (bus_valid && !bus_write)
          m_rd[v] = (bus_addr == 4'h0) ? m_ctrl[v] : (bus_addr == 4'h4) ? dout : 32'h0;
        if (bus_valid && bus_write && bus_addr == 4'h0) begin
          nc = bus_wdata & mask_of(v);
          if (nc[1] && !m_ctrl[v][1]) begin
            a = (v == 1) ? nc[25:16] : nc[15:6];
            m_data[v] = fuse_of(v, a);
          end
          m_ctrl[v] = nc;
        end
      end
    end
  end

  task automatic cmp(int v, logic rv, logic [31:0] rd);
    checks++;
    if (rv !== m_rv[v] || rd !== m_rd[v]) begin
      errors++;
      $display("FAIL %s variant=%0d: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               cur_req, v, rv, rd, m_rv[v], m_rd[v]);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cmp(0, rv_b, rd_b);
      cmp(1, rv_w, rd_w);
    end
  end

  task automatic xfer(logic w, logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  // control value carrying both variants' address fields
  function automatic logic [31:0] cv(logic [31:0] bits, logic [9:0] ab, logic [9:0] aw);
    return bits | {6'b0, aw, 16'b0} | {16'b0, ab, 6'b0};
  endfunction

  localparam logic [31:0] CS = 32'h1, STB = 32'h2, LD = 32'h4, PG = 32'h8,
                          PD = 32'h20, SN = 32'h80, SS = 32'h200;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: standby after reset
    cur_req = "R1";
    xfer(1'b0, 4'h0, 0);
    xfer(1'b0, 4'h4, 0);
    // R2: masked write and readback
    cur_req = "R2";
    xfer(1'b1, 4'h0, 32'hFFFF_FFFF); xfer(1'b0, 4'h0, 0);
    xfer(1'b1, 4'h0, 32'hA5A5_5A5A); xfer(1'b0, 4'h0, 0);
    xfer(1'b1, 4'h0, 32'h0);         xfer(1'b0, 4'h0, 0);
    // R4: read setup, strobe, sample at several addresses
    cur_req = "R4";
    for (int i = 0; i < 6; i++) begin
      logic [9:0] ab, aw;
      ab = 10'(i * 97 + 1); aw = 10'(1023 - i * 131);
      xfer(1'b1, 4'h0, cv(LD | PG | SS | SN, ab, aw));
      xfer(1'b1, 4'h0, cv(LD | PG | SS | SN | STB, ab, aw));
      xfer(1'b0, 4'h4, 0);
      xfer(1'b1, 4'h0, cv(LD | PG | SS | SN, ab, aw));
    end
    // R3: gating by strobe, chip-select and load
    cur_req = "R3";
    xfer(1'b0, 4'h4, 0);
    xfer(1'b1, 4'h0, cv(LD | PG | STB, 10'd5, 10'd9));   xfer(1'b0, 4'h4, 0);
    xfer(1'b1, 4'h0, cv(LD | PG | STB | CS, 10'd5, 10'd9)); xfer(1'b0, 4'h4, 0);
    xfer(1'b1, 4'h0, cv(PG | STB, 10'd5, 10'd9));        xfer(1'b0, 4'h4, 0);
    xfer(1'b1, 4'h0, cv(LD | PG | STB, 10'd5, 10'd9));   xfer(1'b0, 4'h4, 0);
    // R5: address change while strobe high is not captured
    cur_req = "R5";
    xfer(1'b1, 4'h0, cv(LD | PG | STB, 10'd700, 10'd333)); xfer(1'b0, 4'h4, 0);
    xfer(1'b1, 4'h0, cv(LD | PG, 10'd700, 10'd333));
    xfer(1'b1, 4'h0, cv(LD | PG | STB, 10'd700, 10'd333)); xfer(1'b0, 4'h4, 0);
    // R6: power-down forces zero
    cur_req = "R6";
    xfer(1'b1, 4'h0, cv(LD | PG | STB | PD, 10'd700, 10'd333)); xfer(1'b0, 4'h4, 0);
    xfer(1'b1, 4'h0, cv(LD | PG | STB, 10'd700, 10'd333));      xfer(1'b0, 4'h4, 0);
    // R8: writes to other offsets ignored, undefined reads zero
    cur_req = "R8";
    xfer(1'b1, 4'h4, 32'hFFFF_FFFF); xfer(1'b0, 4'h0, 0); xfer(1'b0, 4'h4, 0);
    xfer(1'b1, 4'h8, 32'h0);         xfer(1'b0, 4'h0, 0);
    xfer(1'b1, 4'hC, 32'h0);         xfer(1'b0, 4'h8, 0); xfer(1'b0, 4'hC, 0);
    // R7: mixed traffic, back-to-back and idle cycles
    cur_req = "R7";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      @(negedge clk);
      bus_valid = r[0];
      bus_write = r[1] && r[2];
      bus_addr  = r[3] ? 4'h0 : (r[4] ? 4'h4 : 4'(r[8:5]));
      bus_wdata = (r[6] ? (LD | PG) : 32'h0) | (r[9] ? STB : 32'h0) | ($urandom & 32'h03FF_FFF0)
                  | (r[10] ? CS : 32'h0) | (r[11] ? PD : 32'h0);
    end
    @(negedge clk);
    bus_valid = 1'b0;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected end of stimulus");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule